// File: doc/BRIEF.md
# Hidden Configuration Window Decoder

This block sits on the register port of a disk channel and decides, for every byte or word access at the channel base, whether the access belongs to the attached drive or to a concealed set of configuration registers. Normally every access passes through to the drive. A fixed access pattern opens the concealed space, which then takes over the task-file offsets. The pattern is two back-to-back 16-bit reads at offset 1 followed by a byte write of 0x03 at offset 2. A byte write of 0x83 at offset 2 hides the space again.

While the space is open, it holds the following registers:
- Two timing sets, A and B. Each set has a read-cycle register and a write-cycle register. The low bits of the miscellaneous register choose which set the timing offsets reach.
- A control register, which assigns the timing sets to the drives.
- A read-only version register.

The stored values are driven out continuously to the cycle-timing logic, which is outside this block.

Top module: `cfg_unlock_window`

## Requirements
- R1: The window opens in the cycle after this exact run of accesses: a word read (acc_word=1) at offset 1, another word read at offset 1, then a byte write (acc_word=0) of 0x03 at offset 2.
- R2: Any access that does not fit the pattern returns the detector to idle. This includes a byte read at offset 1, a word write at offset 2, and a wrong key value. A word read at offset 1 always counts as a fresh first read. A third or later such read keeps the "two reads seen" condition.
- R3: While the window is open, a byte write of 0x83 at offset 2 closes it from the next cycle. A word write at offset 2, or a byte write of any other value at offset 2, leaves the window open.
- R4: While the window is closed, the following hold:
  - acc_to_cfg is 0.
  - rd_data is 0xFF.
  - No access changes any stored configuration register.
- R5: While the window is open, every read or write strobe is flagged with acc_to_cfg=1, whatever the offset. When neither strobe is active, the flag is 0.
- R6: While the window is open, offsets 0 and 1 reach the read-cycle and write-cycle timing registers of the set selected by misc bits [SEL_W-1:0]. A value of 0 selects set A and 1 selects set B. Set s sits at bits [8s+7:8s] of tim_rd_o and tim_wr_o. Word writes store the low byte lane of wr_data.
- R7: While the window is open, offset 3 is the read/write control register and offset 6 is the read/write miscellaneous register.
- R8: While the window is open, offset 5 reads the version constant (0x00), and writes to offset 5 have no effect.
- R9: While the window is open, reads of offsets 2, 4 and 7 return 0xFF.
- R10: After reset, the following hold:
  - The window is closed.
  - Every timing register holds 0x00.
  - Control holds 0x85.
  - Miscellaneous holds 0x00.
- R11: A write to one timing set leaves the registers of the other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Read strobe, one access per cycle |
| wr_stb | input | 1 | Write strobe; wins if both strobes are high |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off | input | 3 | Offset from the channel base |
| wr_data | input | DW | Write data, low byte lane |
| rd_data | output | DW | Configuration read data; 0xFF when not a configuration read |
| acc_to_cfg | output | 1 | 1 = current access belongs to configuration space |
| tim_rd_o | output | NUM_SETS*DW | Read-cycle timing of every set, set A in the low byte |
| tim_wr_o | output | NUM_SETS*DW | Write-cycle timing of every set, set A in the low byte |
| ctrl_o | output | DW | Control register |
| misc_o | output | DW | Miscellaneous register |

## Verification
The hardest condition to reach is a near-miss of the unlock pattern, where the detector has to fall back to idle instead of opening.
- One stimulus offers a single word read, then the key.
- Another uses a byte read in place of a word read.
- Another offers the key as a word write.

After each of these, the bench probes offset 3 and expects a pass-through flag, not the control value. A further case of three reads before the key confirms that extra reads do not spoil the pattern. Set B is reached only after the select bit in the miscellaneous register is written. Each set is then loaded with distinct values, so any cross-talk between sets shows on the flat outputs.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int OFF_W = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RD1  = 2'd1,
        SQ_RD2  = 2'd2,
        SQ_OPEN = 2'd3
    } seq_state_e;

    localparam logic [OFF_W-1:0] OFF_TRD   = 3'd0;
    localparam logic [OFF_W-1:0] OFF_TWR   = 3'd1;
    localparam logic [OFF_W-1:0] OFF_PROBE = 3'd1;
    localparam logic [OFF_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_VER   = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;

    localparam logic [7:0] KEY_OPEN  = 8'h03;
    localparam logic [7:0] KEY_CLOSE = 8'h83;

endpackage

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
    import cfgwin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             acc_word,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [DW-1:0]    key_byte,
    output logic             win_open
);

    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic probe_rd, key_wr, any_acc;

    always_comb begin
        nxt_d    = cur_q;
        any_acc  = rd_stb | wr_stb;
        probe_rd = rd_stb && !wr_stb && acc_word && (acc_off == OFF_PROBE);
        key_wr   = wr_stb && !acc_word && (acc_off == OFF_KEY);
        if (any_acc) begin
            unique case (cur_q.st)
                SQ_IDLE: nxt_d.st = probe_rd ? SQ_RD1 : SQ_IDLE;
                SQ_RD1:  nxt_d.st = probe_rd ? SQ_RD2 : SQ_IDLE;
                SQ_RD2: begin
                    if (probe_rd)
                        nxt_d.st = SQ_RD2;
                    else if (key_wr && key_byte == DW'(KEY_OPEN))
                        nxt_d.st = SQ_OPEN;
                    else
                        nxt_d.st = SQ_IDLE;
                end
                SQ_OPEN: begin
                    if (key_wr && key_byte == DW'(KEY_CLOSE))
                        nxt_d.st = SQ_IDLE;
                end
                default: nxt_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '{st: SQ_IDLE};
        else
            cur_q <= nxt_d;
    end

    assign win_open = (cur_q.st == SQ_OPEN);

endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
    import cfgwin_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          NUM_SETS = 2,
    parameter int          SEL_W    = 1,
    parameter logic [DW-1:0] CTRL_RST = 8'h85,
    parameter logic [DW-1:0] MISC_RST = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       acc_off,
    input  logic [DW-1:0]          wdat,
    output logic [NUM_SETS*DW-1:0] tim_rd,
    output logic [NUM_SETS*DW-1:0] tim_wr,
    output logic [DW-1:0]          ctrl,
    output logic [DW-1:0]          misc,
    output logic [SEL_W-1:0]       set_sel
);

    typedef struct packed {
        logic [NUM_SETS-1:0][DW-1:0] trd;
        logic [NUM_SETS-1:0][DW-1:0] twr;
        logic [DW-1:0]               ctrl;
        logic [DW-1:0]               misc;
    } regs_t;

    regs_t rq_q, rq_d;

    assign set_sel = rq_q.misc[SEL_W-1:0];

    always_comb begin
        rq_d = rq_q;
        if (wr_en) begin
            unique case (acc_off)
                OFF_TRD: begin
                    for (int s = 0; s < NUM_SETS; s++)
                        if (set_sel == SEL_W'(s)) rq_d.trd[s] = wdat;
                end
                OFF_TWR: begin
                    for (int s = 0; s < NUM_SETS; s++)
                        if (set_sel == SEL_W'(s)) rq_d.twr[s] = wdat;
                end
                OFF_CTRL: rq_d.ctrl = wdat;
                OFF_MISC: rq_d.misc = wdat;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rq_q <= '{trd: '0, twr: '0, ctrl: CTRL_RST, misc: MISC_RST};
        else
            rq_q <= rq_d;
    end

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_flat
            assign tim_rd[g*DW +: DW] = rq_q.trd[g];
            assign tim_wr[g*DW +: DW] = rq_q.twr[g];
        end
    endgenerate

    assign ctrl = rq_q.ctrl;
    assign misc = rq_q.misc;

endmodule

// File: rtl/cfgwin_rdmux.sv
module cfgwin_rdmux
    import cfgwin_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            NUM_SETS = 2,
    parameter int            SEL_W    = 1,
    parameter logic [DW-1:0] VERSION  = 8'h00
) (
    input  logic                   win_open,
    input  logic [OFF_W-1:0]       acc_off,
    input  logic [SEL_W-1:0]       set_sel,
    input  logic [NUM_SETS*DW-1:0] tim_rd,
    input  logic [NUM_SETS*DW-1:0] tim_wr,
    input  logic [DW-1:0]          ctrl,
    input  logic [DW-1:0]          misc,
    output logic [DW-1:0]          rd_data
);

    always_comb begin
        rd_data = '1;
        if (win_open) begin
            unique case (acc_off)
                OFF_TRD: begin
                    for (int s = 0; s < NUM_SETS; s++)
                        if (set_sel == SEL_W'(s)) rd_data = tim_rd[s*DW +: DW];
                end
                OFF_TWR: begin
                    for (int s = 0; s < NUM_SETS; s++)
                        if (set_sel == SEL_W'(s)) rd_data = tim_wr[s*DW +: DW];
                end
                OFF_CTRL: rd_data = ctrl;
                OFF_VER:  rd_data = VERSION;
                OFF_MISC: rd_data = misc;
                default:  rd_data = '1;
            endcase
        end
    end

endmodule

// File: rtl/cfg_unlock_window.sv
module cfg_unlock_window
    import cfgwin_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            NUM_SETS = 2,
    parameter logic [DW-1:0] VERSION  = 8'h00,
    parameter logic [DW-1:0] CTRL_RST = 8'h85,
    parameter logic [DW-1:0] MISC_RST = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_stb,
    input  logic                   wr_stb,
    input  logic                   acc_word,
    input  logic [2:0]             acc_off,
    input  logic [DW-1:0]          wr_data,
    output logic [DW-1:0]          rd_data,
    output logic                   acc_to_cfg,
    output logic [NUM_SETS*DW-1:0] tim_rd_o,
    output logic [NUM_SETS*DW-1:0] tim_wr_o,
    output logic [DW-1:0]          ctrl_o,
    output logic [DW-1:0]          misc_o
);

    localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    logic             win_open;
    logic [SEL_W-1:0] set_sel;

    cfgwin_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .acc_word (acc_word),
        .acc_off  (acc_off),
        .key_byte (wr_data),
        .win_open (win_open)
    );

    cfgwin_regs #(
        .DW(DW), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W),
        .CTRL_RST(CTRL_RST), .MISC_RST(MISC_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_open && wr_stb),
        .acc_off (acc_off),
        .wdat    (wr_data),
        .tim_rd  (tim_rd_o),
        .tim_wr  (tim_wr_o),
        .ctrl    (ctrl_o),
        .misc    (misc_o),
        .set_sel (set_sel)
    );

    cfgwin_rdmux #(
        .DW(DW), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W), .VERSION(VERSION)
    ) u_rdmux (
        .win_open (win_open),
        .acc_off  (acc_off),
        .set_sel  (set_sel),
        .tim_rd   (tim_rd_o),
        .tim_wr   (tim_wr_o),
        .ctrl     (ctrl_o),
        .misc     (misc_o),
        .rd_data  (rd_data)
    );

    assign acc_to_cfg = win_open && (rd_stb || wr_stb);

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
    parameter int            DW       = 8,
    parameter int            NUM_SETS = 2,
    parameter logic [DW-1:0] VERSION  = 8'h00
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_stb,
    input logic                   wr_stb,
    input logic                   acc_word,
    input logic [2:0]             acc_off,
    input logic [DW-1:0]          wr_data,
    input logic [DW-1:0]          rd_data,
    input logic                   acc_to_cfg,
    input logic                   win_open,
    input logic [NUM_SETS*DW-1:0] tim_rd_o,
    input logic [NUM_SETS*DW-1:0] tim_wr_o,
    input logic [DW-1:0]          ctrl_o,
    input logic [DW-1:0]          misc_o
);

    // R1: the window only ever opens right after a byte key write of 0x03 at offset 2
    a_r1_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(wr_stb && !acc_word && acc_off == 3'd2 && wr_data == DW'(8'h03)));

    // R3: the close key hides the window in the next cycle
    a_r3_close_key: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && wr_stb && !acc_word && acc_off == 3'd2 && wr_data == DW'(8'h83)) |=> !win_open);

    // R4: closed window passes everything to the drive
    a_r4_closed_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> (!acc_to_cfg && rd_data == '1));

    // R4: closed window leaves the stored registers alone
    a_r4_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> ($stable(tim_rd_o) && $stable(tim_wr_o) && $stable(ctrl_o) && $stable(misc_o)));

    // R5: every strobe in an open window is a configuration access
    a_r5_open_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && (rd_stb || wr_stb)) |-> acc_to_cfg);

    // R8: version offset returns the constant
    a_r8_version: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && acc_off == 3'd5) |-> rd_data == VERSION);

    // R9: unmapped offsets read all ones
    a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && (acc_off == 3'd2 || acc_off == 3'd4 || acc_off == 3'd7)) |-> rd_data == '1);

endmodule

bind cfg_unlock_window cfgwin_chk #(.DW(DW), .NUM_SETS(NUM_SETS), .VERSION(VERSION)) u_chk (.*);

// File: tb/sim_cfg_unlock_window.sv
`timescale 1ns/1ps
module sim_cfg_unlock_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, acc_word = 1'b0;
    logic [2:0]  acc_off = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        acc_to_cfg;
    logic [15:0] tim_rd_o, tim_wr_o;
    logic [7:0]  ctrl_o, misc_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] cap_rd;
    logic       cap_cfg;

    always #4 clk = ~clk;

    cfg_unlock_window u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .acc_word(acc_word), .acc_off(acc_off), .wr_data(wr_data),
        .rd_data(rd_data), .acc_to_cfg(acc_to_cfg), .tim_rd_o(tim_rd_o),
        .tim_wr_o(tim_wr_o), .ctrl_o(ctrl_o), .misc_o(misc_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one access for one cycle; capture combinational outputs mid-cycle
    task automatic acc(input logic is_wr, input logic word, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        rd_stb = !is_wr; wr_stb = is_wr; acc_word = word; acc_off = off; wr_data = d;
        #1;
        cap_rd = rd_data; cap_cfg = acc_to_cfg;
    endtask

    task automatic idle();
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; acc_word = 1'b0; acc_off = '0; wr_data = '0;
        #1;
    endtask

    task automatic do_open();
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
        idle();
    endtask

    task automatic do_close();
        acc(1, 0, 3'd2, 8'h83);
        idle();
    endtask

    // probe: flag and read data at control offset tell open or closed
    task automatic probe(input string tag, input logic exp_open);
        acc(0, 0, 3'd3, 8'h00);
        chk(tag, {15'd0, cap_cfg}, {15'd0, exp_open});
        idle();
    endtask

    task automatic t_reset();
        chk("R10 tim_rd reset", tim_rd_o, 16'h0000);
        chk("R10 tim_wr reset", tim_wr_o, 16'h0000);
        chk("R10 ctrl reset", {8'd0, ctrl_o}, 16'h0085);
        chk("R10 misc reset", {8'd0, misc_o}, 16'h0000);
        acc(0, 0, 3'd3, 8'h00);
        chk("R4 closed flag after reset", {15'd0, cap_cfg}, 16'd0);
        chk("R4 closed read data", {8'd0, cap_rd}, 16'h00FF);
        idle();
    endtask

    task automatic t_unlock();
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
        chk("R1 key write itself passes through", {15'd0, cap_cfg}, 16'd0);
        idle();
        acc(0, 0, 3'd3, 8'h00);
        chk("R1 open flag", {15'd0, cap_cfg}, 16'd1);
        chk("R7 control readback", {8'd0, cap_rd}, 16'h0085);
        idle();
    endtask

    task automatic t_close();
        do_close();
        acc(0, 0, 3'd3, 8'h00);
        chk("R3 closed flag", {15'd0, cap_cfg}, 16'd0);
        chk("R3 closed read data", {8'd0, cap_rd}, 16'h00FF);
        idle();
    endtask

    task automatic t_break();
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
        idle();
        probe("R2 one read then key stays closed", 1'b0);
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 0, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
        idle();
        probe("R2 byte read breaks run", 1'b0);
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 1, 3'd2, 8'h03);
        idle();
        probe("R2 word key write does not open", 1'b0);
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h04);
        idle();
        probe("R2 wrong key value does not open", 1'b0);
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(0, 1, 3'd1, 8'h00);
        acc(1, 0, 3'd2, 8'h03);
        idle();
        probe("R2 three reads then key opens", 1'b1);
        do_close();
    endtask

    task automatic t_stay_open();
        do_open();
        acc(1, 1, 3'd2, 8'h83);
        idle();
        probe("R3 word close write keeps open", 1'b1);
        acc(1, 0, 3'd2, 8'h84);
        idle();
        probe("R3 other byte value keeps open", 1'b1);
        do_close();
        probe("R3 byte 0x83 closes", 1'b0);
    endtask

    task automatic t_sets();
        do_open();
        acc(1, 0, 3'd6, 8'h00);
        acc(1, 0, 3'd0, 8'h21);
        acc(1, 1, 3'd1, 8'h32);
        idle();
        chk("R6 set A loaded, set B untouched rd", tim_rd_o, 16'h0021);
        chk("R6 set A loaded, set B untouched wr", tim_wr_o, 16'h0032);
        acc(1, 0, 3'd6, 8'h01);
        acc(1, 0, 3'd0, 8'h43);
        acc(1, 0, 3'd1, 8'h54);
        idle();
        chk("R11 set B write keeps set A rd", tim_rd_o, 16'h4321);
        chk("R11 set B write keeps set A wr", tim_wr_o, 16'h5432);
        chk("R7 misc written", {8'd0, misc_o}, 16'h0001);
        acc(0, 0, 3'd0, 8'h00);
        chk("R6 read set B read timing", {8'd0, cap_rd}, 16'h0043);
        acc(0, 1, 3'd1, 8'h00);
        chk("R6 read set B write timing", {8'd0, cap_rd}, 16'h0054);
        acc(1, 0, 3'd6, 8'h00);
        acc(0, 0, 3'd1, 8'h00);
        chk("R6 read set A write timing", {8'd0, cap_rd}, 16'h0032);
        acc(0, 0, 3'd6, 8'h00);
        chk("R7 misc readback", {8'd0, cap_rd}, 16'h0000);
        acc(1, 0, 3'd3, 8'hC0);
        idle();
        chk("R7 control written", {8'd0, ctrl_o}, 16'h00C0);
        acc(1, 0, 3'd3, 8'h85);
        idle();
        chk("R7 control rewritten", {8'd0, ctrl_o}, 16'h0085);
    endtask

    task automatic t_version_unmapped();
        acc(0, 0, 3'd5, 8'h00);
        chk("R8 version read", {8'd0, cap_rd}, 16'h0000);
        acc(1, 0, 3'd5, 8'h5A);
        chk("R5 flag on version write", {15'd0, cap_cfg}, 16'd1);
        acc(0, 0, 3'd5, 8'h00);
        chk("R8 version unchanged by write", {8'd0, cap_rd}, 16'h0000);
        idle();
        chk("R8 write leaves timing", tim_rd_o, 16'h4321);
        acc(0, 0, 3'd4, 8'h00);
        chk("R9 offset 4 reads FF", {8'd0, cap_rd}, 16'h00FF);
        chk("R5 flag on unmapped read", {15'd0, cap_cfg}, 16'd1);
        acc(0, 0, 3'd7, 8'h00);
        chk("R9 offset 7 reads FF", {8'd0, cap_rd}, 16'h00FF);
        acc(0, 1, 3'd2, 8'h00);
        chk("R9 offset 2 reads FF", {8'd0, cap_rd}, 16'h00FF);
        idle();
        chk("R5 no strobe no flag", {15'd0, acc_to_cfg}, 16'd0);
    endtask

    task automatic t_closed_ignore();
        do_close();
        acc(1, 0, 3'd0, 8'h99);
        chk("R4 closed write flag", {15'd0, cap_cfg}, 16'd0);
        acc(1, 0, 3'd3, 8'h11);
        acc(1, 0, 3'd6, 8'h01);
        acc(1, 1, 3'd1, 8'h77);
        idle();
        chk("R4 closed writes keep rd timing", tim_rd_o, 16'h4321);
        chk("R4 closed writes keep wr timing", tim_wr_o, 16'h5432);
        chk("R4 closed writes keep ctrl", {8'd0, ctrl_o}, 16'h0085);
        chk("R4 closed writes keep misc", {8'd0, misc_o}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock();
        t_close();
        t_break();
        t_stay_open();
        t_sets();
        t_version_unmapped();
        t_closed_ignore();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule